// File: doc/BRIEF.md
# Store Address Router

This block accepts one store per clock cycle and sends it to exactly one of four targets: a program memory of 1024 sixteen-bit words, a byte-wide video RAM organised as 128 columns by 64 rows, a UART register window and an 8-bit LED register. Each store carries a 16-bit address, a 32-bit data word and a valid strobe. The top address bits pick the target through a chain of nested tests. The block then drives a write enable, an address and a suitably narrowed data slice on that target's port.

Routing is combinational from the request. The program memory, video RAM and UART ports therefore show the routed write in the same cycle that the store is presented. The LED register lives inside the block and loads on the clock edge that follows an accepted store. A high-water register records the largest program-memory word address written since reset; a loader uses it to find the end of the image.

The store input follows valid/ready rules. A store counts as accepted in any cycle where `st_valid` and `st_ready` are both high. `st_ready` is held high, because every target takes a write every cycle. No back-pressure is ever applied, and the source may present a new store each cycle.

Top module: `store_router`

## Requirements
- R1: With `st_valid` high, `st_addr[15]`=1 and `st_addr[14]`=0, `pm_we` is 1 in that same cycle, with `pm_addr`=`st_addr[9:0]` and `pm_wdata`=`st_data[15:0]`, whatever `st_addr[13:10]` hold.
- R2: With `st_valid` high and `st_addr[15:14]`=2'b11, `vr_we` is 1 in that same cycle and `vr_wdata`=`st_data[7:0]`.
- R3: For a video RAM write, `vr_col`=`st_addr[6:0]` and `vr_row`=`st_addr[12:7]`, and `st_addr[13]` has no effect.
- R4: With `st_valid` high, `st_addr[15]`=0 and `st_addr[7:6]`=2'b10, `uart_we` is 1 in that same cycle and `uart_idx`=`st_addr[3:0]`, whatever the other address bits hold.
- R5: With `st_valid` high, `st_addr[15]`=0 and `st_addr[7:6]`=2'b00, `led_q` takes `st_data[7:0]` at the next rising clock edge. Otherwise `led_q` holds its value.
- R6: A store with `st_addr[15]`=0 and `st_addr[7:6]` equal to 2'b01 or 2'b11 is dropped. No write enable rises, and `led_q` does not change.
- R7: While `st_valid` is low, none of `pm_we`, `vr_we` or `uart_we` is high and `led_q` holds.
- R8: At most one target is written in any cycle.
- R9: `pm_hiwater` becomes the larger of its current value and `pm_addr` at the clock edge after each program-memory write, so it never decreases between resets.
- R10: While `rst_n` is low, `led_q` and `pm_hiwater` are 0.
- R11: `st_ready` is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | A store is presented |
| st_ready | output | 1 | Store accepted (always high) |
| st_addr | input | 16 | Store address |
| st_data | input | 32 | Store data word |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | 10 | Program memory word address |
| pm_wdata | output | 16 | Program memory write data |
| vr_we | output | 1 | Video RAM write enable |
| vr_col | output | 7 | Video RAM column |
| vr_row | output | 6 | Video RAM row |
| vr_wdata | output | 8 | Video RAM write byte |
| uart_we | output | 1 | UART register write strobe |
| uart_idx | output | 4 | UART register index |
| led_q | output | 8 | LED register contents |
| pm_hiwater | output | 10 | Largest program memory address written since reset |

## Verification
The assertions assume that `st_valid` is low during reset and that the request inputs are stable around the sampling edge. They do not assume that the address falls in a decoded region, because dropped stores are part of the legal input. The bench changes the inputs only on falling clock edges and holds `st_valid` low until reset has been released. It covers every decode region, including the two dropped I/O slots and addresses whose unused upper bits are set. It also applies pseudo-random addresses, with and without valid, so that the one-hot and hold properties see mixed traffic.

// File: rtl/store_route_pkg.sv
package store_route_pkg;
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_PM   = 3'd1,
    TGT_VRAM = 3'd2,
    TGT_UART = 3'd3,
    TGT_LED  = 3'd4
  } tgt_e;
endpackage

// File: rtl/store_route_decode.sv
module store_route_decode
  import store_route_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IO_SEL_HI = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt
);
  localparam int MEM_BIT = ADDR_W - 1;
  localparam int VID_BIT = ADDR_W - 2;
  localparam int IO_SEL_LO = IO_SEL_HI - 1;

  always_comb begin
    tgt = TGT_NONE;
    if (addr[MEM_BIT]) begin
      tgt = addr[VID_BIT] ? TGT_VRAM : TGT_PM;
    end else begin
      unique case (addr[IO_SEL_HI:IO_SEL_LO])
        2'b00:   tgt = TGT_LED;
        2'b10:   tgt = TGT_UART;
        default: tgt = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/store_route_led.sv
module store_route_led #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (wr) q <= d;
  end

  // R5
  led_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q == $past(d));
  // R5
  led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));
endmodule

// File: rtl/store_route_hiwater.sv
module store_route_hiwater #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] mark
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mark <= '0;
    else if (wr && (addr > mark)) mark <= addr;
  end

  // R9
  hiwater_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mark >= $past(mark));
  // R9
  hiwater_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mark));
endmodule

// File: rtl/store_router.sv
module store_router
  import store_route_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int PM_AW   = 10,
  parameter int PM_DW   = 16,
  parameter int VR_CW   = 7,
  parameter int VR_RW   = 6,
  parameter int VR_DW   = 8,
  parameter int UART_IW = 4,
  parameter int LED_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_valid,
  output logic               st_ready,
  input  logic [ADDR_W-1:0]  st_addr,
  input  logic [DATA_W-1:0]  st_data,
  output logic               pm_we,
  output logic [PM_AW-1:0]   pm_addr,
  output logic [PM_DW-1:0]   pm_wdata,
  output logic               vr_we,
  output logic [VR_CW-1:0]   vr_col,
  output logic [VR_RW-1:0]   vr_row,
  output logic [VR_DW-1:0]   vr_wdata,
  output logic               uart_we,
  output logic [UART_IW-1:0] uart_idx,
  output logic [LED_W-1:0]   led_q,
  output logic [PM_AW-1:0]   pm_hiwater
);
  localparam int ROW_LO = VR_CW;
  localparam int ROW_HI = VR_CW + VR_RW - 1;

  tgt_e tgt;
  logic take;
  logic led_we;

  assign st_ready = 1'b1;
  assign take     = st_valid & st_ready;

  store_route_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (st_addr),
    .tgt  (tgt)
  );

  assign pm_we   = take && (tgt == TGT_PM);
  assign vr_we   = take && (tgt == TGT_VRAM);
  assign uart_we = take && (tgt == TGT_UART);
  assign led_we  = take && (tgt == TGT_LED);

  assign pm_addr  = st_addr[PM_AW-1:0];
  assign pm_wdata = st_data[PM_DW-1:0];
  assign vr_col   = st_addr[VR_CW-1:0];
  assign vr_row   = st_addr[ROW_HI:ROW_LO];
  assign vr_wdata = st_data[VR_DW-1:0];
  assign uart_idx = st_addr[UART_IW-1:0];

  store_route_led #(.W(LED_W)) u_led (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (led_we),
    .d     (st_data[LED_W-1:0]),
    .q     (led_q)
  );

  store_route_hiwater #(.AW(PM_AW)) u_hw (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (pm_we),
    .addr  (pm_addr),
    .mark  (pm_hiwater)
  );

  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pm_we, vr_we, uart_we, led_we}));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |-> !(pm_we || vr_we || uart_we || led_we));
  // R6
  drop_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_addr[ADDR_W-1] && st_addr[6]) |-> !(uart_we || led_we || pm_we || vr_we));
  // R11
  always_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> st_ready);
endmodule

// File: tb/store_router_tb.sv
module store_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [15:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic        pm_we, vr_we, uart_we;
  logic [9:0]  pm_addr, pm_hiwater;
  logic [15:0] pm_wdata;
  logic [6:0]  vr_col;
  logic [5:0]  vr_row;
  logic [7:0]  vr_wdata, led_q;
  logic [3:0]  uart_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  store_router u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .vr_we(vr_we), .vr_col(vr_col), .vr_row(vr_row), .vr_wdata(vr_wdata),
    .uart_we(uart_we), .uart_idx(uart_idx),
    .led_q(led_q), .pm_hiwater(pm_hiwater)
  );

  typedef struct {
    logic        pm_we, vr_we, uart_we;
    logic [9:0]  pm_addr;
    logic [15:0] pm_wdata;
    logic [6:0]  col;
    logic [5:0]  row;
    logic [7:0]  vbyte;
    logic [3:0]  uidx;
    logic [7:0]  led;
    logic [9:0]  hw;
  } exp_t;

  exp_t q[$];
  logic [7:0] m_led = '0;
  logic [9:0] m_hw = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [15:0] a, logic [31:0] d);
    exp_t e;
    @(negedge clk);
    st_valid = v; st_addr = a; st_data = d;
    e.pm_we   = v && a[15] && !a[14];
    e.vr_we   = v && a[15] && a[14];
    e.uart_we = v && !a[15] && (a[7:6] == 2'b10);
    e.pm_addr = a[9:0]; e.pm_wdata = d[15:0];
    e.col = a[6:0]; e.row = a[12:7]; e.vbyte = d[7:0];
    e.uidx = a[3:0];
    e.led = m_led; e.hw = m_hw;
    q.push_back(e);
    if (v && !a[15] && (a[7:6] == 2'b00)) m_led = d[7:0];
    if (e.pm_we && (a[9:0] > m_hw)) m_hw = a[9:0];
  endtask

  always @(negedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R1 pm_we", pm_we, e.pm_we);
      if (e.pm_we) begin
        chk("R1 pm_addr", pm_addr, e.pm_addr);
        chk("R1 pm_wdata", pm_wdata, e.pm_wdata);
      end
      chk("R2 vr_we", vr_we, e.vr_we);
      if (e.vr_we) begin
        chk("R2 vr_wdata", vr_wdata, e.vbyte);
        chk("R3 vr_col", vr_col, e.col);
        chk("R3 vr_row", vr_row, e.row);
      end
      chk("R4 uart_we", uart_we, e.uart_we);
      if (e.uart_we) chk("R4 uart_idx", uart_idx, e.uidx);
      chk("R5 R6 R7 led_q", led_q, e.led);
      chk("R9 pm_hiwater", pm_hiwater, e.hw);
      chk("R8 one target", 32'(pm_we + vr_we + uart_we) <= 1, 1);
      chk("R11 st_ready", st_ready, 1'b1);
    end
  end

  initial begin
    #200000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 led_q reset", led_q, 0);
    chk("R10 hiwater reset", pm_hiwater, 0);
    rst_n = 1'b1;
    // R1 plain, and with bits 13:10 set
    drive(1, 16'h8005, 32'hDEAD_BEEF);
    drive(1, 16'hBC10, 32'h0000_1234);
    drive(1, 16'h83FF, 32'h5555_AAAA);
    drive(1, 16'h8100, 32'h1);       // R9 smaller than 0x3FF
    // R2 R3 corners, bit 13 set
    drive(1, 16'hC000, 32'h11);
    drive(1, 16'hDFFF, 32'hFFFF_FF7E);
    drive(1, 16'hFFFF, 32'h42);
    drive(1, 16'hE0C5, 32'h99);
    // R4 UART
    drive(1, 16'h0085, 32'h0);
    drive(1, 16'h3A8F, 32'h0);
    // R5 LED
    drive(1, 16'h0000, 32'h0000_00A5);
    drive(1, 16'h1234, 32'hFFFF_FF3C);
    // R6 dropped slots
    drive(1, 16'h0040, 32'hFF);
    drive(1, 16'h00C0, 32'h77);
    drive(1, 16'h7FFF, 32'h12);
    // R7 valid low on LED and PM addresses
    drive(0, 16'h0000, 32'h66);
    drive(0, 16'h83FF, 32'h66);
    // mixed traffic
    for (int i = 0; i < 400; i++) drive($urandom_range(0, 3) != 0, 16'($urandom), $urandom);
    drive(0, 16'h0, 32'h0);
    drive(0, 16'h0, 32'h0);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule